// File: doc/BRIEF.md
# Polled Rotary Encoder Step Decoder

This block turns a two-phase rotary encoder, already debounced outside the chip, into single-clock step pulses: one output pulses for a clockwise notch and the other for a counter-clockwise notch. The encoder is not watched on every clock. A prescaler counts sample-period strobes and looks at the encoder once every `PRESCALE` strobes. This slow polling rate is enough to catch every detent of a hand-turned knob.

A notch is recognised when phase A is seen low at a sampling instant and was not already marked low. A remembered flag holds the "A seen low" state between sampling instants. The level of phase B at that instant gives the direction. Both phases pass through a synchronizer before they are used. A counter or register that consumes the pulses sits outside this block.

Top module: `enc_step_decoder`

## Requirements
- R1: The encoder is sampled only on the strobe that brings the prescaler to its end. That is every `PRESCALE`-th strobe (default 64), counted from reset, with the first sample on strobe number `PRESCALE`. Clocks without a strobe do not advance the prescaler.
- R2: A sampling instant that sees phase A high clears the low flag and gives no pulse.
- R3: A sampling instant that sees phase A low while the low flag is already set gives no pulse.
- R4: A sampling instant that sees phase A low with the flag clear is a falling edge and sets the flag. If phase B is low (0) at that instant, `step_up` pulses.
- R5: On such a falling edge, if phase B is high (1), `step_dn` pulses.
- R6: Each pulse lasts exactly one clock. `step_up` and `step_dn` are never high together, and a sampling instant gives at most one pulse.
- R7: While `rst_n` is low, and right after reset, both outputs are low and the low flag is clear. The synchronized phase A resets to high, so reset alone never creates an edge.
- R8: Phase values that change and return between two sampling instants have no effect. The pulse output is decided only by the synchronized levels at the sampling strobe. The phases must be held for at least `SYNC_STAGES`+1 clocks before that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample-period strobe, one clock wide |
| ph_a | input | 1 | Encoder phase A (its falling edge marks a notch) |
| ph_b | input | 1 | Encoder phase B (gives the direction) |
| step_up | output | 1 | One-clock pulse for a right turn |
| step_dn | output | 1 | One-clock pulse for a left turn |

## Verification
Three things happen on the same clock at a sampling strobe: the prescaler reload, the edge decision, and the update of the low flag. If the flag were written before it was read, or the reload were off by one strobe, the result would be a lost or extra pulse. The bench keeps its own strobe count and its own flag model. A driver queues one expected result per window, and the monitor compares the outputs in the cycle after each `PRESCALE`-th strobe. Between windows it flags any stray pulse. Windows with idle gaps between strobes and with a phase A glitch that is cleared before the sample show the window boundary and the ignore rule at the ports.

// File: rtl/enc_step_decoder.sv
module enc_step_decoder #(
  parameter int unsigned PRESCALE    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ph_a,
  input  logic ph_b,
  output logic step_up,
  output logic step_dn
);
  localparam int unsigned CW = $clog2(PRESCALE + 1);

  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic [CW-1:0]          cnt;
  logic                   a_low;

  wire a_s      = a_sync[SYNC_STAGES-1];
  wire b_s      = b_sync[SYNC_STAGES-1];
  wire sample   = tick && (cnt == CW'(1));
  wire edge_hit = sample && !a_s && !a_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sync <= '1;
      b_sync <= '0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], ph_a};
      b_sync <= {b_sync[SYNC_STAGES-2:0], ph_b};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= CW'(PRESCALE);
    else if (tick)
      cnt <= (cnt == CW'(1)) ? CW'(PRESCALE) : cnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      a_low <= 1'b0;
    else if (sample)
      a_low <= !a_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= edge_hit && !b_s;
      step_dn <= edge_hit &&  b_s;
    end
endmodule

// File: rtl/enc_step_decoder_chk.sv
module enc_step_decoder_chk #(
  parameter int unsigned PRESCALE = 64
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic step_up,
  input logic step_dn,
  input logic a_low
);
  localparam int unsigned CW = $clog2(PRESCALE + 1);

  logic [CW-1:0] seen;
  logic          hit_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen  <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= tick && (seen == CW'(PRESCALE - 1));
      if (tick) seen <= (seen == CW'(PRESCALE - 1)) ? '0 : seen + CW'(1);
    end

  assert_on_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> hit_q);
  assert_up_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> a_low);
  assert_dn_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> a_low);
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
  assert_up_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> !step_up);
  assert_dn_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> !step_dn);
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(a_low));
endmodule

bind enc_step_decoder enc_step_decoder_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .step_up(step_up), .step_dn(step_dn), .a_low(a_low)
);

// File: tb/test_enc_step_decoder.sv
module test_enc_step_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int PS         = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ph_a = 1'b1, ph_b = 1'b0;
  logic step_up, step_dn;

  int checks = 0, errors = 0, stray = 0, tcount = 0, cycles = 0;
  bit samp = 1'b0, model_low = 1'b0, done = 1'b0;
  logic [1:0] expq[$];
  string      tagq[$];

  enc_step_decoder #(.PRESCALE(PS)) i_enc_step_decoder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ph_a(ph_a), .ph_b(ph_b),
    .step_up(step_up), .step_dn(step_dn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {up,dn} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one sampling window: PS strobes, with optional gap cycles and an early A glitch
  task automatic window(input logic a, input logic b, input string req,
                        input int gap = 0, input bit glitch = 1'b0);
    logic [1:0] exp;
    if (glitch) ph_a = ~a;
    for (int i = 0; i < PS; i++) begin
      if (glitch && i == 5) ph_a = a;
      if (!glitch && i == PS - 8) begin ph_a = a; ph_b = b; end
      if (glitch && i == 0) ph_b = b;
      if (i == PS - 1) begin
        exp = 2'b00;
        if (a) model_low = 1'b0;
        else if (!model_low) begin
          model_low = 1'b1;
          exp = b ? 2'b01 : 2'b10;
        end
        expq.push_back(exp);
        tagq.push_back(req);
      end
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    samp = 1'b0;
    if (rst_n && tick) begin
      tcount++;
      samp = (tcount % PS == 0);
    end
  end

  always @(negedge clk) begin
    if (samp && expq.size() > 0) begin
      check(tagq.pop_front(), {step_up, step_dn}, expq.pop_front());
      check("R8 quiet between samples", stray[1:0], 2'b00);
      stray = 0;
    end else if (step_up || step_dn) begin
      stray++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset outputs", {step_up, step_dn}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 after reset", {step_up, step_dn}, 2'b00);
    window(1'b1, 1'b0, "R2 A high no step");
    window(1'b0, 1'b0, "R4 edge B low up");
    window(1'b0, 1'b1, "R3 A still low");
    window(1'b1, 1'b1, "R2 A high clears");
    window(1'b0, 1'b1, "R5 edge B high down");
    window(1'b1, 1'b0, "R2 A high again");
    window(1'b1, 1'b0, "R8 glitch ignored", 0, 1'b1);
    window(1'b0, 1'b0, "R1 gapped strobes up", 2);
    window(1'b0, 1'b0, "R3 no repeat", 1);
    window(1'b1, 1'b1, "R2 release");
    window(1'b0, 1'b1, "R6 single down");
    repeat (5) @(negedge clk);
    check("R6 pulses cleared", {step_up, step_dn}, 2'b00);
    check("R1 all samples seen", 2'(expq.size()), 2'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule